// File: doc/BRIEF.md
# Banked NIC Host Register File with Interrupt Status

This block is the byte-wide host-side register front end of a simple Ethernet controller. The host writes and reads through a 4-bit offset. Offset 0 is always the command byte, and the top two bits of that byte choose which bank answers at offsets 1 to 15. The banks hold the receive ring limits, the boundary pointer, the transmit start page and length, the remote DMA address and length, the receive configuration, the interrupt mask, the station address, the current receive page and the multicast filter mask.

The block also owns the interrupt status byte. Host writes clear its bits by writing ones. One-cycle event pulses from the surrounding datapath set its bits, and a command can also set bits when it completes at once. A level interrupt output is high whenever an unmasked status bit in positions 6:0 is set. When the host commands a transmit, the block pulses a transmit request and presents the start page and byte count beside it. The frame engines and the DMA movers are outside this block.

Top module: `nic_pagereg`

## Requirements
- R1: After reset the status byte reads 0x80, the command byte reads 0x01 (stop, bank 0), and irq and tx_req are low.
- R2: Offset 0 reads and writes the command byte in every bank. Command bits 7:6 choose the bank for offsets 1–15. Bank 0 holds the control registers and bank 1 holds the address filter. In banks 2 and 3, writes have no effect and reads return 0x00.
- R3: In bank 0, a write to offset 1 sets the ring start, offset 2 the ring stop, offset 3 the boundary, offset 12 the receive configuration, and offset 15 the interrupt mask. Each of these reads back at the same offset.
- R4: The transmit count (bank 0, write offsets 5 low / 6 high), the remote start address (offsets 8/9) and the remote count (offsets 10/11) are 16-bit values. A write to one byte replaces only that half, and the value reads back at the same offsets.
- R5: In bank 1, offsets 1–6 hold station address bytes 0–5, offset 7 holds the current page, and offsets 8–15 hold multicast mask bytes 0–7. All of them read back.
- R6: A write to bank 0 offset 7 clears each status bit in positions 6:0 that is written as 1. Status bit 7 is never cleared this way.
- R7: A command write with bit 0 (stop) clear clears status bit 7 (reset done). A command write with bit 0 set leaves it unchanged.
- R8: irq is high exactly when (status AND mask AND 0x7F) is nonzero. It follows any change of status or mask by the next clock edge.
- R9: A command write with stop clear and bit 3 (remote read) or bit 4 (remote write) set sets status bit 6 at the same edge if the remote count is zero. It does not set bit 6 if the count is nonzero or the stop bit is set.
- R10: A command write with stop clear and bit 2 (transmit) set does four things. It raises tx_req for exactly one cycle after the write edge, with tx_page and tx_count carrying the bank 0 offset 4 page and the 16-bit transmit count. It sets status bit 1. It makes the transmit status (bank 0 read offset 4) read 0x01. It stores the command with bit 2 cleared. With the stop bit set, a transmit command raises no request.
- R11: A one-cycle pulse on evt_set[k] sets status bit k. If a pulse and a host write-one-to-clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr in the selected bank (combinational) |
| evt_set | input | 7 | One-cycle pulses that set status bits 6:0 |
| irq | output | 1 | Level interrupt request |
| tx_req | output | 1 | One-cycle transmit request |
| tx_page | output | 8 | Transmit start page |
| tx_count | output | 16 | Transmit byte count |

## Verification
The bench builds the block with its package defaults: six station bytes and eight multicast bytes. This puts every address-filter register of bank 1 within reach of directed readback. It also lets the bench step through all four banks, so it can show that bank 2 and 3 writes leave bank 0 untouched. The remaining scenarios cover the same-cycle corner cases: set against clear, zero-count DMA completion, and transmit with the stop bit set or clear.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;
    localparam int STA_BYTES = 6;
    localparam int MC_BYTES  = 8;
    localparam int OFFS      = 16;

    localparam logic [7:0] CMD_STOP  = 8'h01;
    localparam logic [7:0] CMD_XMIT  = 8'h04;
    localparam logic [7:0] CMD_RDRD  = 8'h08;
    localparam logic [7:0] CMD_RDWR  = 8'h10;
    localparam int ST_TX_OK   = 1;
    localparam int ST_DMA_END = 6;
    localparam int ST_RST     = 7;

    typedef struct packed {
        logic [7:0]                    cmd;
        logic [7:0]                    ring_start;
        logic [7:0]                    ring_stop;
        logic [7:0]                    boundary;
        logic [7:0]                    xmit_page;
        logic [7:0]                    xmit_stat;
        logic [15:0]                   xmit_cnt;
        logic [15:0]                   rdma_addr;
        logic [15:0]                   rdma_cnt;
        logic [7:0]                    rx_cfg;
        logic [7:0]                    int_mask;
        logic [7:0]                    cur_page;
        logic [STA_BYTES-1:0][7:0]     station;
        logic [MC_BYTES-1:0][7:0]      mcast;
        logic                          xmit_req;
    } regs_t;
endpackage

// File: rtl/nic_bank_decode.sv
module nic_bank_decode #(
    parameter int AW = 4
) (
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [1:0]      bank,
    output logic            cmd_we,
    output logic [(1<<AW)-1:0] b0_we,
    output logic [(1<<AW)-1:0] b1_we
);
    localparam int N = 1 << AW;

    always_comb begin
        cmd_we = wr && (addr == '0);
        for (int i = 0; i < N; i++) begin
            b0_we[i] = wr && (i != 0) && (addr == AW'(i)) && (bank == 2'd0);
            b1_we[i] = wr && (i != 0) && (addr == AW'(i)) && (bank == 2'd1);
        end
    end
endmodule

// File: rtl/nic_intr_ctrl.sv
module nic_intr_ctrl #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-2:0] set_bits,
    input  logic [SW-1:0] clr_bits,
    input  logic [SW-1:0] mask,
    output logic [SW-1:0] status,
    output logic          irq
);
    logic [SW-1:0] stat_d, stat_q;
    logic          irq_d,  irq_q;

    always_comb begin
        stat_d = (stat_q & ~clr_bits) | {1'b0, set_bits};
        irq_d  = |(stat_d[SW-2:0] & mask[SW-2:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= {1'b1, {(SW-1){1'b0}}};
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            irq_q  <= irq_d;
        end
    end

    assign status = stat_q;
    assign irq    = irq_q;
endmodule

// File: rtl/nic_pagereg.sv
module nic_pagereg
    import nic_reg_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [3:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic [6:0]  evt_set,
    output logic        irq,
    output logic        tx_req,
    output logic [7:0]  tx_page,
    output logic [15:0] tx_count
);
    localparam int N = 1 << AW;

    regs_t       r_d, r_q;
    logic        cmd_we;
    logic [N-1:0] b0_we, b1_we;
    logic [6:0]  set_bits;
    logic [7:0]  clr_bits;
    logic [7:0]  status;
    logic        go;

    // wires seen by the bound checker
    logic [7:0]  cmd_val;
    logic [7:0]  isr_val;
    logic [15:0] rcnt_val;

    nic_bank_decode #(.AW(AW)) u_dec (
        .wr(host_wr), .addr(host_addr[AW-1:0]), .bank(r_q.cmd[7:6]),
        .cmd_we(cmd_we), .b0_we(b0_we), .b1_we(b1_we)
    );

    always_comb begin
        r_d          = r_q;
        r_d.xmit_req = 1'b0;
        set_bits     = evt_set;
        clr_bits     = '0;
        go           = cmd_we && !host_wdata[0];

        if (cmd_we) begin
            r_d.cmd = host_wdata;
            if (go) begin
                clr_bits[ST_RST] = 1'b1;
                if ((host_wdata & (CMD_RDRD | CMD_RDWR)) != 8'h00 && r_q.rdma_cnt == 16'h0)
                    set_bits[ST_DMA_END] = 1'b1;
                if ((host_wdata & CMD_XMIT) != 8'h00) begin
                    r_d.xmit_req         = 1'b1;
                    r_d.xmit_stat        = 8'h01;
                    set_bits[ST_TX_OK]   = 1'b1;
                    r_d.cmd              = host_wdata & ~CMD_XMIT;
                end
            end
        end

        if (b0_we[1])  r_d.ring_start        = host_wdata;
        if (b0_we[2])  r_d.ring_stop         = host_wdata;
        if (b0_we[3])  r_d.boundary          = host_wdata;
        if (b0_we[4])  r_d.xmit_page         = host_wdata;
        if (b0_we[5])  r_d.xmit_cnt[7:0]     = host_wdata;
        if (b0_we[6])  r_d.xmit_cnt[15:8]    = host_wdata;
        if (b0_we[7])  clr_bits[6:0]         = host_wdata[6:0];
        if (b0_we[8])  r_d.rdma_addr[7:0]    = host_wdata;
        if (b0_we[9])  r_d.rdma_addr[15:8]   = host_wdata;
        if (b0_we[10]) r_d.rdma_cnt[7:0]     = host_wdata;
        if (b0_we[11]) r_d.rdma_cnt[15:8]    = host_wdata;
        if (b0_we[12]) r_d.rx_cfg            = host_wdata;
        if (b0_we[15]) r_d.int_mask          = host_wdata;

        for (int i = 0; i < STA_BYTES; i++)
            if (b1_we[1+i]) r_d.station[i] = host_wdata;
        if (b1_we[STA_BYTES+1]) r_d.cur_page = host_wdata;
        for (int i = 0; i < MC_BYTES; i++)
            if (b1_we[STA_BYTES+2+i]) r_d.mcast[i] = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.cmd <= CMD_STOP;
        end else begin
            r_q <= r_d;
        end
    end

    nic_intr_ctrl #(.SW(8)) u_intr (
        .clk(clk), .rst_n(rst_n), .set_bits(set_bits), .clr_bits(clr_bits),
        .mask(r_d.int_mask), .status(status), .irq(irq)
    );

    always_comb begin
        host_rdata = 8'h00;
        if (host_addr == 4'd0) begin
            host_rdata = r_q.cmd;
        end else if (r_q.cmd[7:6] == 2'd0) begin
            case (host_addr)
                4'd1:  host_rdata = r_q.ring_start;
                4'd2:  host_rdata = r_q.ring_stop;
                4'd3:  host_rdata = r_q.boundary;
                4'd4:  host_rdata = r_q.xmit_stat;
                4'd5:  host_rdata = r_q.xmit_cnt[7:0];
                4'd6:  host_rdata = r_q.xmit_cnt[15:8];
                4'd7:  host_rdata = status;
                4'd8:  host_rdata = r_q.rdma_addr[7:0];
                4'd9:  host_rdata = r_q.rdma_addr[15:8];
                4'd10: host_rdata = r_q.rdma_cnt[7:0];
                4'd11: host_rdata = r_q.rdma_cnt[15:8];
                4'd12: host_rdata = r_q.rx_cfg;
                4'd15: host_rdata = r_q.int_mask;
                default: host_rdata = 8'h00;
            endcase
        end else if (r_q.cmd[7:6] == 2'd1) begin
            for (int i = 0; i < STA_BYTES; i++)
                if (host_addr == 4'(1+i)) host_rdata = r_q.station[i];
            if (host_addr == 4'(STA_BYTES+1)) host_rdata = r_q.cur_page;
            for (int i = 0; i < MC_BYTES; i++)
                if (host_addr == 4'(STA_BYTES+2+i)) host_rdata = r_q.mcast[i];
        end
    end

    assign tx_req   = r_q.xmit_req;
    assign tx_page  = r_q.xmit_page;
    assign tx_count = r_q.xmit_cnt;
    assign cmd_val  = r_q.cmd;
    assign isr_val  = status;
    assign rcnt_val = r_q.rdma_cnt;
endmodule

module nic_pagereg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic [3:0]  host_addr,
    input logic [7:0]  host_wdata,
    input logic [6:0]  evt_set,
    input logic        irq,
    input logic        tx_req,
    input logic [7:0]  cmd_val,
    input logic [7:0]  isr_val,
    input logic [15:0] rcnt_val
);
    AST_RST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 4'd0 && !host_wdata[0]) |=> !isr_val[7]); // R7

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 4'd7 && cmd_val[7:6] == 2'd0 && isr_val[7]) |=> isr_val[7]); // R6

    AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 4'hF && cmd_val[7:6] == 2'd0 && host_wdata == 8'h00) |=> !irq); // R8

    AST_ZERO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 4'd0 && !host_wdata[0] && (host_wdata[3] || host_wdata[4])
         && rcnt_val == 16'h0) |=> isr_val[6]); // R9

    AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req); // R10

    AST_TX_BIT_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> !cmd_val[2]); // R10

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != 7'h0) |=> ((isr_val[6:0] & $past(evt_set)) == $past(evt_set))); // R11
endmodule

bind nic_pagereg nic_pagereg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .evt_set(evt_set), .irq(irq), .tx_req(tx_req),
    .cmd_val(cmd_val), .isr_val(isr_val), .rcnt_val(rcnt_val)
);

// File: tb/test_nic_pagereg.sv
`timescale 1ns/1ps
module test_nic_pagereg;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        host_wr = 0;
    logic [3:0]  host_addr = 0;
    logic [7:0]  host_wdata = 0;
    logic [7:0]  host_rdata;
    logic [6:0]  evt_set = 0;
    logic        irq, tx_req;
    logic [7:0]  tx_page;
    logic [15:0] tx_count;
    int          n_run = 0, n_bad = 0;
    logic [7:0]  rv;

    always #10 clk = ~clk;

    nic_pagereg i_nic_pagereg (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_set(evt_set),
        .irq(irq), .tx_req(tx_req), .tx_page(tx_page), .tx_count(tx_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // drive at negedge, register at posedge, return at next negedge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic t_reset;
        rd(4'd7, rv); chk("R1 status", rv, 8'h80);
        rd(4'd0, rv); chk("R1 cmd", rv, 8'h01);
        chk("R1 irq", irq, 0);
        chk("R1 tx_req", tx_req, 0);
    endtask

    task automatic t_bank0;
        wr(4'd1, 8'h46); wr(4'd2, 8'h80); wr(4'd3, 8'h4C); wr(4'd12, 8'h04);
        rd(4'd1, rv); chk("R3 ring start", rv, 8'h46);
        rd(4'd2, rv); chk("R3 ring stop", rv, 8'h80);
        rd(4'd3, rv); chk("R3 boundary", rv, 8'h4C);
        rd(4'd12, rv); chk("R3 rx cfg", rv, 8'h04);
        wr(4'd8, 8'h34); wr(4'd9, 8'h12); wr(4'd8, 8'hAB);
        rd(4'd8, rv); chk("R4 rsar lo", rv, 8'hAB);
        rd(4'd9, rv); chk("R4 rsar hi kept", rv, 8'h12);
        wr(4'd11, 8'h07);
        rd(4'd10, rv); chk("R4 rcnt lo", rv, 8'h00);
        rd(4'd11, rv); chk("R4 rcnt hi", rv, 8'h07);
        wr(4'd11, 8'h00);
    endtask

    task automatic t_bank1;
        wr(4'd0, 8'h41);  // bank 1, stop kept
        for (int i = 1; i < 16; i++) wr(4'(i), 8'(8'h10 + i));
        for (int i = 1; i < 16; i++) begin
            rd(4'(i), rv); chk("R5 bank1 readback", rv, 8'(8'h10 + i));
        end
        rd(4'd0, rv); chk("R2 cmd on bank1", rv, 8'h41);
        wr(4'd0, 8'h81);  // bank 2
        wr(4'd1, 8'hEE);
        rd(4'd1, rv); chk("R2 bank2 reads 0", rv, 8'h00);
        wr(4'd0, 8'hC1);  // bank 3
        wr(4'd3, 8'hEE);
        rd(4'd3, rv); chk("R2 bank3 reads 0", rv, 8'h00);
        wr(4'd0, 8'h01);
        rd(4'd1, rv); chk("R2 bank2 write ignored", rv, 8'h46);
        rd(4'd3, rv); chk("R2 bank3 write ignored", rv, 8'h4C);
        rd(4'd7, rv); chk("R7 stop set keeps reset bit", rv, 8'h80);
    endtask

    task automatic t_irq;
        wr(4'd15, 8'hFF);
        chk("R8 bit7 not an irq source", irq, 0);
        rd(4'd15, rv); chk("R3 mask", rv, 8'hFF);
        wr(4'd7, 8'hFF);
        rd(4'd7, rv); chk("R6 bit7 survives w1c", rv, 8'h80);
        @(negedge clk); evt_set = 7'h05; @(negedge clk); evt_set = 0;
        rd(4'd7, rv); chk("R11 evt set", rv, 8'h85);
        chk("R8 irq on", irq, 1);
        wr(4'd7, 8'h01);
        rd(4'd7, rv); chk("R6 partial clear", rv, 8'h84);
        wr(4'd15, 8'h01);
        chk("R8 masked off", irq, 0);
        wr(4'd15, 8'h04);
        chk("R8 mask on", irq, 1);
        // same-cycle set and clear of bit 2
        @(negedge clk); host_wr = 1; host_addr = 4'd7; host_wdata = 8'h04; evt_set = 7'h04;
        @(negedge clk); host_wr = 0; evt_set = 0;
        rd(4'd7, rv); chk("R11 set wins", rv, 8'h84);
        wr(4'd7, 8'h7F);
        chk("R8 irq off after clear", irq, 0);
    endtask

    task automatic t_dma;
        wr(4'd0, 8'h09);  // stop + remote read: nothing
        rd(4'd7, rv); chk("R9 stop set no dma end", rv, 8'h80);
        wr(4'd0, 8'h0A);  // start + remote read, count 0
        rd(4'd7, rv); chk("R9 zero count completes, R7 reset cleared", rv, 8'h40);
        wr(4'd7, 8'h40);
        wr(4'd10, 8'h05);
        wr(4'd0, 8'h12);  // remote write, count 5
        rd(4'd7, rv); chk("R9 nonzero count", rv, 8'h00);
        rd(4'd0, rv); chk("R2 cmd readback", rv, 8'h12);
    endtask

    task automatic t_tx;
        wr(4'd4, 8'h40); wr(4'd5, 8'h3C); wr(4'd6, 8'h01);
        wr(4'd0, 8'h05);  // stop + transmit
        chk("R10 no request while stopped", tx_req, 0);
        @(negedge clk); host_wr = 1; host_addr = 4'd0; host_wdata = 8'h06;
        @(negedge clk); host_wr = 0;
        chk("R10 tx_req", tx_req, 1);
        chk("R10 tx_page", tx_page, 8'h40);
        chk("R10 tx_count", tx_count, 16'h013C);
        rd(4'd0, rv); chk("R10 cmd bit2 cleared", rv, 8'h02);
        rd(4'd4, rv); chk("R10 tx status", rv, 8'h01);
        rd(4'd7, rv); chk("R10 status tx ok", rv, 8'h02);
        rd(4'd5, rv); chk("R4 tcnt lo", rv, 8'h3C);
        @(negedge clk);
        chk("R10 single pulse", tx_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bank0();
        t_bank1();
        t_irq();
        t_dma();
        t_tx();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_run++; n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule